// File: doc/BRIEF.md
# Temperature Limit Alarm Status Logic

This block watches the results of a temperature converter for two zones, an on-die local zone and a remote diode zone. Each time the converter signals a finished conversion, both readings are compared against their own programmable high and low limits, and a separate flag reporting an open-circuit remote diode is sampled. Any condition found sets a sticky bit in an 8-bit status register that a host reads through a register interface.

A status bit stays set until the host reads the register. At that read it drops only if the condition seen at the most recent conversion is gone. Otherwise it stays set and waits for a later read. Any status bit that is set also latches an alert request. The request drives an active-low enable for an open-drain alert pad. The request is released only after the status register has been cleared and the host has completed an alert-response cycle. One configuration bit hides the alert at the pad without touching the status bits or the request.

Top module: `tas_top`

## Requirements
- R1: On a conversion strobe, a reading strictly greater than its zone's high limit sets that zone's high bit: local-high is status bit 6 and remote-high is status bit 4. A reading equal to the high limit sets nothing.
- R2: On a conversion strobe, a reading less than or equal to its zone's low limit sets that zone's low bit: local-low is status bit 5 and remote-low is status bit 3.
- R3: Each zone is compared only against its own limit pair, so a reading that passes one zone's limits and fails the other's flags only the zone whose limits it fails.
- R4: On a conversion strobe with `diode_open` high, status bit 2 is set.
- R5: Readings, limits and the diode flag have no effect on status while `conv_done` is low.
- R6: A set status bit stays set across later conversions whose condition is false, until a status read.
- R7: A status read clears a bit only if its condition is false at the latest conversion. A conversion in the same cycle as the read counts as the latest one. If the condition holds, the bit stays set.
- R8: Any status bit becoming set drives `alert_n` to 0 in the same cycle that the bit appears, and `alert_n` stays 0 while the request is held.
- R9: While `cfg` bit 7 is 1, `alert_n` is 1. Status bits and the held request are unaffected, so clearing bit 7 exposes a held request at once.
- R10: The alert request is released only by an `ara_ack` pulse in a cycle where the status register is all zero. An `ara_ack` pulse while any bit is set has no effect. A new alarm in the same cycle as the release keeps the request held.
- R11: After reset, `status` is 0x00 and `alert_n` is 1.
- R12: Readings and limits are 8-bit two's-complement values and are compared as signed numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: new readings are valid |
| local_temp | input | 8 | Local zone reading, signed |
| remote_temp | input | 8 | Remote zone reading, signed |
| diode_open | input | 1 | Remote diode open-circuit flag, sampled on the strobe |
| local_hi_lim | input | 8 | Local high limit, signed |
| local_lo_lim | input | 8 | Local low limit, signed |
| remote_hi_lim | input | 8 | Remote high limit, signed |
| remote_lo_lim | input | 8 | Remote low limit, signed |
| cfg | input | 8 | Configuration register; bit 7 masks the alert pad |
| stat_rd | input | 1 | One-cycle strobe: host reads `status` in this cycle |
| ara_ack | input | 1 | One-cycle strobe: an alert-response cycle was acknowledged |
| status | output | 8 | Sticky status register |
| alert_n | output | 1 | Active-low open-drain enable; 0 pulls the alert pad low |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a status read and a conversion: when both strobes fall on one clock, the bench expects the new conversion to decide the clear. A bit whose condition ends in that conversion must drop, and a bit first raised in it must survive the read. The second pair is an alert-response acknowledge and a fresh alarm: the bench drives both strobes at one clock while the status is clear, and expects the request to stay held with the new bit visible.

// File: rtl/tas_pkg.sv
// Package: tas_pkg
// Shared status-bit positions, configuration bit position and the per-zone
// flag type for the temperature limit alarm logic.
// Assumes an 8-bit status register; unused positions read as zero.
package tas_pkg;

    localparam int unsigned TEMP_W   = 8;
    localparam int unsigned STAT_W   = 8;
    localparam int unsigned N_ZONES  = 2;

    // Zone indices
    localparam int unsigned ZONE_LOCAL  = 0;
    localparam int unsigned ZONE_REMOTE = 1;

    // Status bit positions (software decodes these)
    localparam int unsigned BIT_LOC_HI  = 6;
    localparam int unsigned BIT_LOC_LO  = 5;
    localparam int unsigned BIT_REM_HI  = 4;
    localparam int unsigned BIT_REM_LO  = 3;
    localparam int unsigned BIT_OPEN    = 2;

    // Configuration bit that hides the alert pad
    localparam int unsigned CFG_ALERT_MASK = 7;

    typedef struct packed {
        logic above;   // reading strictly above high limit
        logic below;   // reading at or below low limit
    } zone_flags_t;

endpackage

// File: rtl/tas_zone_cmp.sv
// Module: tas_zone_cmp
// Purely combinational limit check for one zone. Compares a signed reading
// against a signed high and low limit.
// Assumes: all values are two's-complement of width TW; the caller qualifies
// the result with its conversion strobe.
module tas_zone_cmp
    import tas_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic [TW-1:0] reading,
    input  logic [TW-1:0] hi_lim,
    input  logic [TW-1:0] lo_lim,
    output zone_flags_t   flags
);

    // Signed compare of the reading against both limits
    always_comb begin
        flags.above = $signed(reading) >  $signed(hi_lim);
        flags.below = $signed(reading) <= $signed(lo_lim);
    end

endmodule

// File: rtl/tas_sticky_status.sv
// Module: tas_sticky_status
// Sticky status register with conditional clear-on-read. Each bit is set
// by a conversion whose condition is true. A read clears the bit only when
// the condition seen at the latest conversion is false. A conversion in the
// same cycle as the read counts as the latest one.
// Assumes: conv_done and stat_rd are single-cycle strobes.
module tas_sticky_status #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_done,
    input  logic [W-1:0] cond_new,
    input  logic         stat_rd,
    output logic [W-1:0] stat_q,
    output logic         set_any
);

    logic [W-1:0] cond_q;
    logic [W-1:0] cond_cur;
    logic [W-1:0] stat_d;

    // Latest condition: this cycle's conversion if present, else the stored one
    always_comb begin
        cond_cur = conv_done ? cond_new : cond_q;
        set_any  = conv_done && (|cond_new);
    end

    // Hold the condition vector of the latest conversion
    always_ff @(posedge clk) begin
        if (!rst_n)         cond_q <= '0;
        else if (conv_done) cond_q <= cond_new;
    end

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            // Next value of one status bit: set beats read-clear
            always_comb begin
                stat_d[b] = stat_q[b];
                if (stat_rd && !cond_cur[b]) stat_d[b] = 1'b0;
                if (conv_done && cond_new[b]) stat_d[b] = 1'b1;
            end

            // Register one status bit
            always_ff @(posedge clk) begin
                if (!rst_n) stat_q[b] <= 1'b0;
                else        stat_q[b] <= stat_d[b];
            end

            AST_SET_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
                conv_done && cond_new[b] |=> stat_q[b]);                          // R6
            AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !conv_done && !stat_q[b] |=> !stat_q[b]);                         // R5
            AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                stat_q[b] && !stat_rd |=> stat_q[b]);                             // R6
            AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                stat_rd && stat_q[b] && cond_cur[b] |=> stat_q[b]);               // R7
            AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                stat_rd && !conv_done && !cond_q[b] |=> !stat_q[b]);              // R7
        end
    endgenerate

endmodule

// File: rtl/tas_alert_hold.sv
// Module: tas_alert_hold
// Holds the alert request from the first alarm until the status register is
// clear and an alert-response cycle is acknowledged. The mask hides the pad
// only and leaves the held request alone.
// Assumes: set_any marks a cycle in which at least one status bit is set.
module tas_alert_hold #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_any,
    input  logic [W-1:0] stat_q,
    input  logic         ara_ack,
    input  logic         mask,
    output logic         alert_n
);

    logic pend_q;
    logic release_ok;

    // Release allowed only on acknowledge with an empty status register
    always_comb release_ok = ara_ack && (stat_q == '0);

    // Request register: a new alarm wins over a release in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (set_any)    pend_q <= 1'b1;
        else if (release_ok) pend_q <= 1'b0;
    end

    // Active-low pad enable, hidden by the mask
    always_comb alert_n = !(pend_q && !mask);

    AST_PEND_COVERS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_q) |-> pend_q);                                                    // R8
    AST_RELEASE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(ara_ack) && ($past(stat_q) == '0));               // R10

endmodule

// File: rtl/tas_top.sv
// Module: tas_top
// Temperature limit alarm status logic for a local and a remote zone.
// Compares both readings on each conversion strobe, samples the diode-open
// flag, keeps sticky status bits and drives an active-low alert enable.
// Assumes: strobes are single-cycle and synchronous to clk; the host
// samples status in the cycle that stat_rd is high.
module tas_top
    import tas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [TEMP_W-1:0] local_temp,
    input  logic [TEMP_W-1:0] remote_temp,
    input  logic              diode_open,
    input  logic [TEMP_W-1:0] local_hi_lim,
    input  logic [TEMP_W-1:0] local_lo_lim,
    input  logic [TEMP_W-1:0] remote_hi_lim,
    input  logic [TEMP_W-1:0] remote_lo_lim,
    input  logic [STAT_W-1:0] cfg,
    input  logic              stat_rd,
    input  logic              ara_ack,
    output logic [STAT_W-1:0] status,
    output logic              alert_n
);

    logic [TEMP_W-1:0] zone_rd [N_ZONES];
    logic [TEMP_W-1:0] zone_hi [N_ZONES];
    logic [TEMP_W-1:0] zone_lo [N_ZONES];
    zone_flags_t       zone_f  [N_ZONES];
    logic [STAT_W-1:0] cond_new;
    logic              set_any;
    logic              unused_cfg;

    // Gather the per-zone inputs into arrays
    always_comb begin
        zone_rd[ZONE_LOCAL]  = local_temp;
        zone_hi[ZONE_LOCAL]  = local_hi_lim;
        zone_lo[ZONE_LOCAL]  = local_lo_lim;
        zone_rd[ZONE_REMOTE] = remote_temp;
        zone_hi[ZONE_REMOTE] = remote_hi_lim;
        zone_lo[ZONE_REMOTE] = remote_lo_lim;
    end

    genvar z;
    generate
        for (z = 0; z < N_ZONES; z++) begin : g_zone
            tas_zone_cmp #(.TW(TEMP_W)) i_cmp (
                .reading (zone_rd[z]),
                .hi_lim  (zone_hi[z]),
                .lo_lim  (zone_lo[z]),
                .flags   (zone_f[z])
            );
        end
    endgenerate

    // Place each condition at its status bit position
    always_comb begin
        cond_new             = '0;
        cond_new[BIT_LOC_HI] = zone_f[ZONE_LOCAL].above;
        cond_new[BIT_LOC_LO] = zone_f[ZONE_LOCAL].below;
        cond_new[BIT_REM_HI] = zone_f[ZONE_REMOTE].above;
        cond_new[BIT_REM_LO] = zone_f[ZONE_REMOTE].below;
        cond_new[BIT_OPEN]   = diode_open;
    end

    // Only the mask bit of the configuration register is used here
    always_comb unused_cfg = ^{cfg[CFG_ALERT_MASK-1:0]};

    tas_sticky_status #(.W(STAT_W)) i_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .cond_new  (cond_new),
        .stat_rd   (stat_rd),
        .stat_q    (status),
        .set_any   (set_any)
    );

    tas_alert_hold #(.W(STAT_W)) i_alert (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_any (set_any),
        .stat_q  (status),
        .ara_ack (ara_ack),
        .mask    (cfg[CFG_ALERT_MASK]),
        .alert_n (alert_n)
    );

    AST_REM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && ($signed(remote_temp) > $signed(remote_hi_lim))
        |=> status[BIT_REM_HI]);                                                  // R1
    AST_LOC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && ($signed(local_temp) <= $signed(local_lo_lim))
        |=> status[BIT_LOC_LO]);                                                  // R2
    AST_OPEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && diode_open |=> status[BIT_OPEN]);                            // R4
    AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[BIT_LOC_HI]) && !cfg[CFG_ALERT_MASK] |-> !alert_n);          // R8

endmodule

// File: tb/test_tas_top.sv
// Directed bench for tas_top: one task per scenario, each checking its results.
module test_tas_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [7:0] local_temp = 8'd30;
    logic [7:0] remote_temp = 8'd30;
    logic       diode_open = 1'b0;
    logic [7:0] local_hi_lim = 8'd50;
    logic [7:0] local_lo_lim = 8'd10;
    logic [7:0] remote_hi_lim = 8'd80;
    logic [7:0] remote_lo_lim = 8'hEC;   // -20
    logic [7:0] cfg = 8'h00;
    logic       stat_rd = 1'b0;
    logic       ara_ack = 1'b0;
    logic [7:0] status;
    logic       alert_n;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tas_top i_tas_top (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done),
        .local_temp(local_temp), .remote_temp(remote_temp), .diode_open(diode_open),
        .local_hi_lim(local_hi_lim), .local_lo_lim(local_lo_lim),
        .remote_hi_lim(remote_hi_lim), .remote_lo_lim(remote_lo_lim),
        .cfg(cfg), .stat_rd(stat_rd), .ara_ack(ara_ack),
        .status(status), .alert_n(alert_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // One conversion strobe; results are visible at the following negedge
    task automatic conv(input logic [7:0] l, input logic [7:0] r, input logic op);
        @(negedge clk);
        local_temp = l; remote_temp = r; diode_open = op; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0; diode_open = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        stat_rd = 1'b1; v = status;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic rd_conv(input logic [7:0] l, input logic [7:0] r, output logic [7:0] v);
        @(negedge clk);
        local_temp = l; remote_temp = r; conv_done = 1'b1; stat_rd = 1'b1; v = status;
        @(negedge clk);
        conv_done = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic ara;
        @(negedge clk); ara_ack = 1'b1;
        @(negedge clk); ara_ack = 1'b0;
    endtask

    task automatic clean;
        logic [7:0] v;
        conv(8'd30, 8'd30, 1'b0);
        rd(v);
        ara();
    endtask

    task automatic t_reset;
        chk("R11", "status after reset", status, 8'h00);
        chk("R11", "alert_n after reset", {7'd0, alert_n}, 8'h01);
    endtask

    task automatic t_high;
        conv(8'd51, 8'd80, 1'b0);
        chk("R1", "local 51 over 50, remote equal 80", status, 8'h40);
        chk("R8", "alert_n on alarm", {7'd0, alert_n}, 8'h00);
        conv(8'd30, 8'd81, 1'b0);
        chk("R1", "remote 81 over 80", status, 8'h50);
        clean();
    endtask

    task automatic t_low;
        conv(8'd10, 8'hED, 1'b0);       // local equal low, remote -19
        chk("R2", "local at low limit", status, 8'h20);
        clean();
        conv(8'd11, 8'hEC, 1'b0);       // remote equal -20
        chk("R2", "remote at low limit", status, 8'h08);
        clean();
    endtask

    task automatic t_signed;
        conv(8'd30, 8'h9C, 1'b0);       // remote -100
        chk("R12", "remote -100 is low not high", status, 8'h08);
        clean();
        conv(8'h80, 8'd30, 1'b0);       // local -128
        chk("R12", "local -128 is low not high", status, 8'h20);
        clean();
    endtask

    task automatic t_zones;
        conv(8'd60, 8'd60, 1'b0);
        chk("R3", "60 trips local high only", status, 8'h40);
        clean();
        conv(8'hF1, 8'hF1, 1'b0);       // -15 both
        chk("R3", "-15 trips local low only", status, 8'h20);
        clean();
    endtask

    task automatic t_open;
        conv(8'd30, 8'd30, 1'b1);
        chk("R4", "diode open flag", status, 8'h04);
        clean();
    endtask

    task automatic t_nostrobe;
        @(negedge clk);
        local_temp = 8'd100; remote_temp = 8'd100; diode_open = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5", "no strobe, no status", status, 8'h00);
        chk("R5", "no strobe, no alert", {7'd0, alert_n}, 8'h01);
        local_temp = 8'd30; remote_temp = 8'd30; diode_open = 1'b0;
    endtask

    task automatic t_sticky;
        conv(8'd60, 8'd30, 1'b0);
        conv(8'd30, 8'd30, 1'b0);
        chk("R6", "bit held after condition gone", status, 8'h40);
        repeat (3) @(negedge clk);
        chk("R6", "bit held while idle", status, 8'h40);
        clean();
    endtask

    task automatic t_read;
        logic [7:0] v;
        conv(8'd60, 8'd30, 1'b0);
        rd(v);
        chk("R7", "read value", v, 8'h40);
        chk("R7", "read with condition present keeps bit", status, 8'h40);
        conv(8'd30, 8'd30, 1'b0);
        rd(v);
        chk("R7", "read after condition gone clears", status, 8'h00);
        chk("R10", "alert held after clear without ack", {7'd0, alert_n}, 8'h00);
        ara();
        // read coinciding with a conversion whose condition is gone
        conv(8'd60, 8'd30, 1'b0);
        rd_conv(8'd30, 8'd30, v);
        chk("R7", "same-cycle read and clean conversion clears", status, 8'h00);
        ara();
        // read coinciding with a conversion that raises a new alarm
        rd_conv(8'd60, 8'd30, v);
        chk("R7", "same-cycle read and new alarm keeps bit", status, 8'h40);
        clean();
    endtask

    task automatic t_mask;
        @(negedge clk); cfg = 8'h80;
        conv(8'd60, 8'd30, 1'b0);
        chk("R9", "status set while masked", status, 8'h40);
        chk("R9", "alert_n high while masked", {7'd0, alert_n}, 8'h01);
        cfg = 8'h00;
        @(negedge clk);
        chk("R9", "unmask exposes held alert", {7'd0, alert_n}, 8'h00);
        clean();
        chk("R10", "alert released after clean", {7'd0, alert_n}, 8'h01);
    endtask

    task automatic t_ara;
        logic [7:0] v;
        conv(8'd60, 8'd30, 1'b0);
        ara();
        chk("R10", "ack with status set: alert kept", {7'd0, alert_n}, 8'h00);
        chk("R10", "ack with status set: status kept", status, 8'h40);
        conv(8'd30, 8'd30, 1'b0);
        rd(v);
        chk("R10", "status cleared, alert still held", {7'd0, alert_n}, 8'h00);
        // acknowledge and new alarm in the same cycle
        @(negedge clk);
        local_temp = 8'd60; conv_done = 1'b1; ara_ack = 1'b1;
        @(negedge clk);
        conv_done = 1'b0; ara_ack = 1'b0;
        chk("R10", "ack with new alarm: alert held", {7'd0, alert_n}, 8'h00);
        chk("R10", "ack with new alarm: status", status, 8'h40);
        clean();
        chk("R10", "ack with empty status releases", {7'd0, alert_n}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_high();
        t_low();
        t_signed();
        t_zones();
        t_open();
        t_nostrobe();
        t_sticky();
        t_read();
        t_mask();
        t_ara();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule